// File: doc/BRIEF.md
# Latched Alert Status Controller

This block holds the sticky condition flags of a power module and drives the active-low alert line toward the host. Each monitored condition arrives as a synchronous level on its own input bit. A short strobe is a one-cycle level. When a condition rises, its flag is set and the alert line drops on the same clock edge. The flag stays set until the host acknowledges it. The flags are packed into a 16-bit status word. Its low byte is a grouped summary, and its high byte gives individual detail.

Four host actions release the alert and wipe every flag:
- a clear-faults command strobe;
- a status-word read strobe;
- an off-then-on cycle of the enable pin;
- an off-then-on cycle of the commanded output-on level.

A condition that is still present when a clear happens is picked up again one cycle later from its live level. The alert then drops again. Bus decoding is outside this block, so every host action arrives here as a decoded strobe or level.

Top module: `fault_alert_ctrl`

## Requirements
- R1: While reset is applied and right after it, the status word reads 0 and `alert_n_o` is 1.
- R2: Condition inputs use this bit order: 0 input undervoltage, 1 input overvoltage, 2 output undervoltage, 3 output overvoltage, 4 overcurrent, 5 overtemperature warning, 6 overtemperature fault, 7 fan failure, 8 communication error, 9 PEC error, 10 invalid command, 11 internal fault. A bit that was low at the previous edge and is high at this edge sets its flag, and `alert_n_o` goes low at that same edge.
- R3: A set flag stays set after its condition goes low, and `alert_n_o` stays low, until a clear event occurs.
- R4: A clear event clears every flag and drives `alert_n_o` high at that edge. A clear event is any of the following:
  - `clr_faults_i` high;
  - `rd_status_i` high;
  - a rising edge of `en_pin_i`;
  - a rising edge of `op_on_i`.
  Both on-levels count as on at reset, so an edge counts only after a low level has been seen.
- R5: At the edge after a clear event, every condition input that is high sets its flag, even without a new edge. A condition that is high only in the clear cycle is lost.
- R6: The low byte of the status word is laid out as follows:
  - bit 0: internal fault;
  - bit 1: communication, PEC or invalid command;
  - bit 2: either temperature condition;
  - bit 3: fan failure;
  - bit 4: either input voltage condition;
  - bit 5: overcurrent;
  - bit 6: either output voltage condition;
  - bit 7: any flag set.
- R7: The high byte of the status word gives these individual flags:
  - bit 8: input undervoltage;
  - bit 9: input overvoltage;
  - bit 10: output undervoltage;
  - bit 11: output overvoltage;
  - bit 12: overtemperature warning;
  - bit 13: overtemperature fault;
  - bit 14: PEC error;
  - bit 15: invalid command.
- R8: `alert_n_o` is 0 exactly when at least one flag is set, and then status bit 7 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 12 | Live condition levels, bit order as in R2 |
| clr_faults_i | input | 1 | Clear-faults command strobe |
| rd_status_i | input | 1 | Status-word read strobe |
| en_pin_i | input | 1 | Enable pin level, 1 = output on |
| op_on_i | input | 1 | Commanded output-on level |
| status_word_o | output | 16 | Packed status word |
| alert_n_o | output | 1 | Active-low alert line |

## Verification
The properties assume the following about the inputs:
- Every condition, strobe and on-level input is synchronous to the clock and settled before each rising edge.
- Strobes may coincide freely with condition edges and with each other.

The stimulus changes every input shortly after a rising edge and holds it until the next edge. Condition bits toggle sparsely, so both long levels and one-cycle strobes occur. Clear sources fire at random, including on the same edge as a condition rise and in the re-evaluation cycle that follows another clear.

// File: rtl/fault_alert_pkg.sv
`timescale 1ns/1ps
package fault_alert_pkg;
  localparam int N_COND = 12;
  localparam int WORD_W = 16;

  localparam int C_VIN_UV   = 0;
  localparam int C_VIN_OV   = 1;
  localparam int C_VOUT_UV  = 2;
  localparam int C_VOUT_OV  = 3;
  localparam int C_IOUT_OC  = 4;
  localparam int C_OT_WARN  = 5;
  localparam int C_OT_FAULT = 6;
  localparam int C_FAN      = 7;
  localparam int C_COMM     = 8;
  localparam int C_PEC      = 9;
  localparam int C_INVALID  = 10;
  localparam int C_INTERNAL = 11;

  // Grouped summary byte (R6) plus per-condition detail byte (R7).
  function automatic logic [WORD_W-1:0] pack_word(input logic [N_COND-1:0] s);
    logic [WORD_W-1:0] w;
    w     = '0;
    w[0]  = s[C_INTERNAL];
    w[1]  = s[C_COMM] | s[C_PEC] | s[C_INVALID];
    w[2]  = s[C_OT_WARN] | s[C_OT_FAULT];
    w[3]  = s[C_FAN];
    w[4]  = s[C_VIN_UV] | s[C_VIN_OV];
    w[5]  = s[C_IOUT_OC];
    w[6]  = s[C_VOUT_UV] | s[C_VOUT_OV];
    w[7]  = |s;
    w[8]  = s[C_VIN_UV];
    w[9]  = s[C_VIN_OV];
    w[10] = s[C_VOUT_UV];
    w[11] = s[C_VOUT_OV];
    w[12] = s[C_OT_WARN];
    w[13] = s[C_OT_FAULT];
    w[14] = s[C_PEC];
    w[15] = s[C_INVALID];
    return w;
  endfunction
endpackage

// File: rtl/fa_rise_det.sv
`timescale 1ns/1ps
module fa_rise_det #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] lvl_q,
  output logic [W-1:0] rise
);
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= RST_VAL;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/fa_recycle.sv
`timescale 1ns/1ps
module fa_recycle #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_on,
  output logic             cycled
);
  logic [N_SRC-1:0] on_edge;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic seen_q;
    // Starts as "on": an edge counts only after a low level has been seen.
    always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= 1'b1;
      else        seen_q <= src_on[g];
    end
    assign on_edge[g] = src_on[g] & ~seen_q;
  end

  assign cycled = |on_edge;
endmodule

// File: rtl/fa_sticky_bank.sv
`timescale 1ns/1ps
module fa_sticky_bank #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise,
  input  logic         clr,
  output logic [W-1:0] sticky_q,
  output logic [W-1:0] sticky_nxt,
  output logic         reeval_q
);
  always_comb begin
    if (clr) sticky_nxt = '0;
    else     sticky_nxt = sticky_q | rise | (reeval_q ? lvl : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      reeval_q <= 1'b0;
    end else begin
      sticky_q <= sticky_nxt;
      reeval_q <= clr;
    end
  end
endmodule

// File: rtl/fault_alert_ctrl.sv
`timescale 1ns/1ps
module fault_alert_ctrl
  import fault_alert_pkg::*;
#(
  parameter int N_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_COND-1:0] cond_i,
  input  logic              clr_faults_i,
  input  logic              rd_status_i,
  input  logic              en_pin_i,
  input  logic              op_on_i,
  output logic [WORD_W-1:0] status_word_o,
  output logic              alert_n_o
);
  logic [N_COND-1:0] cond_q;
  logic [N_COND-1:0] cond_rise;
  logic [N_COND-1:0] sticky_q;
  logic [N_COND-1:0] sticky_nxt;
  logic              reeval_q;
  logic              out_cycled;
  logic              clr_evt;
  logic              alert_n_q;

  fa_rise_det #(.W(N_COND), .RST_VAL('0)) u_cond_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (cond_i),
    .lvl_q (cond_q),
    .rise  (cond_rise)
  );

  fa_recycle #(.N_SRC(N_SRC)) u_recycle (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_on ({op_on_i, en_pin_i}),
    .cycled (out_cycled)
  );

  assign clr_evt = clr_faults_i | rd_status_i | out_cycled;

  fa_sticky_bank #(.W(N_COND)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl        (cond_i),
    .rise       (cond_rise),
    .clr        (clr_evt),
    .sticky_q   (sticky_q),
    .sticky_nxt (sticky_nxt),
    .reeval_q   (reeval_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) alert_n_q <= 1'b1;
    else        alert_n_q <= ~(|sticky_nxt);
  end

  assign alert_n_o     = alert_n_q;
  assign status_word_o = pack_word(sticky_q);
endmodule

// File: rtl/fault_alert_chk.sv
`timescale 1ns/1ps
module fault_alert_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cond,
  input logic [W-1:0] cond_q,
  input logic [W-1:0] sticky,
  input logic         clr_evt,
  input logic         reeval,
  input logic         alert_n,
  input logic [15:0]  word
);
  // R2: a fresh condition edge outside a clear pulls the alert low next edge
  p_rise_alerts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_evt && |(cond & ~cond_q)) |=> !alert_n);

  // R3: without a clear, no flag is ever dropped
  p_sticky_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_evt |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R4: a clear empties the flags and releases the alert
  p_clear_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (alert_n && (sticky == '0)));

  // R5: live levels re-raise the alert in the cycle after a clear
  p_reeval_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reeval && !clr_evt && |cond) |=> !alert_n);

  // R8: alert line and summary bit agree with the flag set
  p_summary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word[7] == !alert_n) && (alert_n == (sticky == '0)));
endmodule

bind fault_alert_ctrl fault_alert_chk #(.W(fault_alert_pkg::N_COND)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cond    (cond_i),
  .cond_q  (cond_q),
  .sticky  (sticky_q),
  .clr_evt (clr_evt),
  .reeval  (reeval_q),
  .alert_n (alert_n_o),
  .word    (status_word_o)
);

// File: tb/tb_fault_alert_ctrl.sv
`timescale 1ns/1ps
module tb_fault_alert_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cond = '0;
  logic        cf = 1'b0, rd = 1'b0, en = 1'b1, op = 1'b1;
  wire  [15:0] word;
  wire         alert_n;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // reference state
  logic [11:0] m_st, m_cq;
  logic        m_re, m_enq, m_opq;

  always #4 clk = ~clk;

  fault_alert_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cond_i(cond), .clr_faults_i(cf),
    .rd_status_i(rd), .en_pin_i(en), .op_on_i(op),
    .status_word_o(word), .alert_n_o(alert_n)
  );

  function automatic logic [15:0] exp_word(input logic [11:0] s);
    logic [7:0] hi, lo;
    hi = {s[10], s[9], s[6], s[5], s[3], s[2], s[1], s[0]};
    lo = {(s != 0), (s[2] | s[3]), s[4], (s[0] | s[1]), s[7],
          (s[5] | s[6]), (s[8] | s[9] | s[10]), s[11]};
    return {hi, lo};
  endfunction

  task automatic check(input string r, input logic [15:0] a, input logic [15:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, a, e, $time);
    end
  endtask

  task automatic model_reset();
    m_st = '0; m_cq = '0; m_re = 1'b0; m_enq = 1'b1; m_opq = 1'b1;
  endtask

  task automatic tick(input string r);
    logic clr;
    @(posedge clk);
    clr = cf | rd | (en & ~m_enq) | (op & ~m_opq);
    if (clr) m_st = '0;
    else     m_st = m_st | (cond & ~m_cq) | (m_re ? cond : 12'h0);
    m_re = clr; m_cq = cond; m_enq = en; m_opq = op;
    #1;
    check(r, word, exp_word(m_st));
    check(r, {15'b0, alert_n}, {15'b0, (m_st == 0)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check("R1", word, 16'h0000);
    check("R1", {15'b0, alert_n}, 16'h0001);
    rst_n = 1'b1;
    tick("R1");
    check("R1", word, 16'h0000);

    // R2 overcurrent edge
    cond[4] = 1'b1; tick("R2");
    check("R6", word, 16'h00A0);
    check("R2", {15'b0, alert_n}, 16'h0000);
    // R3 held after condition goes away
    cond[4] = 1'b0; tick("R3"); tick("R3");
    check("R3", word, 16'h00A0);
    // input undervoltage held through a clear-faults
    cond[0] = 1'b1; tick("R7");
    check("R7", word, 16'h01B0);
    cf = 1'b1; tick("R4");
    check("R4", word, 16'h0000);
    check("R4", {15'b0, alert_n}, 16'h0001);
    cf = 1'b0; tick("R5");
    check("R5", word, 16'h0190);
    check("R5", {15'b0, alert_n}, 16'h0000);
    // status read clears, nothing live afterwards
    cond[0] = 1'b0; rd = 1'b1; tick("R4");
    rd = 1'b0; tick("R5");
    check("R5", word, 16'h0000);
    // PEC strobe, then enable pin cycle
    cond[9] = 1'b1; tick("R7");
    cond[9] = 1'b0;
    check("R7", word, 16'h4082);
    en = 1'b0; tick("R4");
    check("R4", word, 16'h4082);
    en = 1'b1; tick("R4");
    check("R4", word, 16'h0000);
    // overtemperature fault, then operation-command cycle
    cond[6] = 1'b1; tick("R7");
    check("R7", word, 16'h2084);
    cond[6] = 1'b0; op = 1'b0; tick("R4");
    check("R4", word, 16'h2084);
    op = 1'b1; tick("R4"); tick("R5");
    check("R4", word, 16'h0000);
    // strobe only inside the clear cycle is lost
    cond[10] = 1'b1; cf = 1'b1; tick("R5");
    cond[10] = 1'b0; cf = 1'b0; tick("R5");
    check("R5", word, 16'h0000);
    check("R8", {15'b0, alert_n}, 16'h0001);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      for (int b = 0; b < 12; b++) if ($urandom_range(15) == 0) cond[b] = ~cond[b];
      cf = ($urandom_range(19) == 0);
      rd = ($urandom_range(24) == 0);
      if ($urandom_range(29) == 0) en = ~en;
      if ($urandom_range(29) == 0) op = ~op;
      tick("R8");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule